// File: doc/BRIEF.md
# Slot-Selected Banked Memory Window

This block decodes a 16K-word region of a 16-bit processor's word address space and routes accesses in that region to an expansion slot. A separate I/O write picks the active slot and a two-bit map mode. Only one slot, number 10, is populated here, by a built-in RAM split into a lower and an upper half. Through the window that slot shows one of three things: a fixed card identification word, the lower half of the RAM, or the upper half. Every other slot reads as zero and ignores writes.

The memory side is a request/response stream. A request carries an address, a write flag, write data and a per-bit write mask. `req_ready` is held high, so every cycle with `req_valid` high moves exactly one request. A cycle therefore carries either a read or a write, never both. A read produces one response one cycle later. A write produces no response. The response stream has no ready input, so the consumer must take each response in the cycle it is offered. The slot-select port is a plain control input. Its two-bit sub-address becomes the map mode, and data bits 13:8 become the slot number.

The size of each RAM half is set by `HALF_AW`. The default of 10 gives 1K words per half. A full-size build sets it to 14, which gives 16K words per half and 32K in total. When a half is smaller than the window, window offsets wrap modulo the half size.

Top module: `bankwin_top`

## Requirements
- R1: After reset the selected slot is 0 and the map mode is 3, so window reads return 0x0000 until a select write occurs.
- R2: A select write (`sel_we` high) sets the map mode to `sel_sub` and the slot to `sel_data[13:8]`. All other data bits are ignored.
- R3: When the selected slot is not 10, window reads return 0x0000 and window writes leave the RAM unchanged.
- R4: With slot 10 and map mode 0, a window read returns 0x0402 at any window address.
- R5: With slot 10 and map mode 0, window writes leave the RAM unchanged.
- R6: With slot 10 and map mode 1, the window offset addresses the lower RAM half. That half is independent of the upper half.
- R7: With slot 10 and map modes 2 and 3, the window offset addresses the upper RAM half, and both modes reach the same words.
- R8: A write replaces only the bits set in `req_wmask`. All other bits keep their previous value.
- R9: `rsp_valid` is high exactly in the cycle after an accepted read and in no other cycle. Writes produce no response, and responses stay in request order.
- R10: The window covers word addresses 0x4000–0x7FFF. Reads outside it return 0x0000, and writes outside it leave the RAM unchanged. Inside it, the offset is taken modulo the half size.
- R11: `req_ready` is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Slot-select write strobe |
| sel_sub | input | 2 | Select sub-address, becomes the map mode |
| sel_data | input | 16 | Select write data, bits 13:8 give the slot |
| req_valid | input | 1 | Memory request valid |
| req_ready | output | 1 | Memory request accepted (always high) |
| req_we | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_wmask | input | 16 | Per-bit write mask |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Read response data |

## Verification
On every cycle, the assertions check the response timing, the always-ready request side and the effect of select writes on the internal slot and mode state. They also check the zero data returned for unselected slots and for addresses outside the window, and the constant identification word in mode 0. Some behaviour shows only in RAM contents, which the assertions cannot see. Only the bench's write-then-read scenarios can show that mode-0 and foreign-slot writes leave the RAM unchanged, that modes 2 and 3 alias, that the two halves hold separate data, that masked writes merge bits, and that offsets wrap.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

  typedef enum logic [1:0] {
    MAP_ID   = 2'd0,
    MAP_LO   = 2'd1,
    MAP_HI_A = 2'd2,
    MAP_HI_B = 2'd3
  } map_mode_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ID   = 2'd1,
    SRC_RAM  = 2'd2
  } rsp_src_e;

endpackage

// File: rtl/bankwin_sel_reg.sv
module bankwin_sel_reg
  import bankwin_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SLOT_W   = 6,
  parameter int SLOT_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sub,
  input  logic [DATA_W-1:0] data,
  output logic [SLOT_W-1:0] slot_o,
  output map_mode_e         mode_o
);

  wire unused_data = ^data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_o <= '0;
      mode_o <= MAP_HI_B;
    end else if (we) begin
      slot_o <= data[SLOT_LSB +: SLOT_W];
      mode_o <= map_mode_e'(sub);
    end
  end

endmodule

// File: rtl/bankwin_decode.sv
module bankwin_decode
  import bankwin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_AW   = 14,
  parameter int WIN_SEL  = 1,
  parameter int SLOT_W   = 6,
  parameter int RAM_SLOT = 10,
  parameter int HALF_AW  = 10,
  localparam int TAG_W   = ADDR_W - WIN_AW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SLOT_W-1:0] slot,
  input  map_mode_e         mode,
  output logic              id_sel,
  output logic              ram_sel,
  output logic [HALF_AW:0]  ram_addr
);

  logic in_win;
  logic slot_hit;
  wire  unused_addr = ^addr;

  assign in_win   = (addr[ADDR_W-1:WIN_AW] == TAG_W'(WIN_SEL));
  assign slot_hit = (slot == SLOT_W'(RAM_SLOT));
  assign id_sel   = in_win && slot_hit && (mode == MAP_ID);
  assign ram_sel  = in_win && slot_hit && (mode != MAP_ID);

  // Modes 2 and 3 share the upper half through bit 1 of the mode.
  assign ram_addr = {mode[1], addr[HALF_AW-1:0]};

endmodule

// File: rtl/bankwin_ram.sv
module bankwin_ram #(
  parameter int DATA_W = 16,
  parameter int AW     = 11,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= (mem[addr] & ~wmask) | (wdata & wmask);
    end
    if (rd_en) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/bankwin_top.sv
module bankwin_top
  import bankwin_pkg::*;
#(
  parameter int ADDR_W           = 16,
  parameter int DATA_W           = 16,
  parameter int WIN_AW           = 14,
  parameter int WIN_SEL          = 1,
  parameter int SLOT_W           = 6,
  parameter int SLOT_LSB         = 8,
  parameter int RAM_SLOT         = 10,
  parameter int HALF_AW          = 10,
  parameter logic [15:0] CARD_ID = 16'h0402
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_we,
  input  logic [1:0]        sel_sub,
  input  logic [DATA_W-1:0] sel_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] req_wmask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int RAM_AW = HALF_AW + 1;

  logic [SLOT_W-1:0] slot_q;
  map_mode_e         mode_q;
  logic              id_sel;
  logic              ram_sel;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_rdata;
  logic              rd_fire;
  logic              wr_fire;
  rsp_src_e          src_q;
  logic              rsp_valid_q;

  assign req_ready = 1'b1;
  assign rd_fire   = req_valid && !req_we;
  assign wr_fire   = req_valid && req_we;

  bankwin_sel_reg #(
    .DATA_W  (DATA_W),
    .SLOT_W  (SLOT_W),
    .SLOT_LSB(SLOT_LSB)
  ) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (sel_we),
    .sub   (sel_sub),
    .data  (sel_data),
    .slot_o(slot_q),
    .mode_o(mode_q)
  );

  bankwin_decode #(
    .ADDR_W  (ADDR_W),
    .WIN_AW  (WIN_AW),
    .WIN_SEL (WIN_SEL),
    .SLOT_W  (SLOT_W),
    .RAM_SLOT(RAM_SLOT),
    .HALF_AW (HALF_AW)
  ) u_dec (
    .addr    (req_addr),
    .slot    (slot_q),
    .mode    (mode_q),
    .id_sel  (id_sel),
    .ram_sel (ram_sel),
    .ram_addr(ram_addr)
  );

  bankwin_ram #(
    .DATA_W(DATA_W),
    .AW    (RAM_AW)
  ) u_ram (
    .clk  (clk),
    .wr_en(wr_fire && ram_sel),
    .rd_en(rd_fire && ram_sel),
    .addr (ram_addr),
    .wdata(req_wdata),
    .wmask(req_wmask),
    .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      src_q       <= SRC_ZERO;
    end else begin
      rsp_valid_q <= rd_fire;
      if (rd_fire) begin
        if (id_sel)       src_q <= SRC_ID;
        else if (ram_sel) src_q <= SRC_RAM;
        else              src_q <= SRC_ZERO;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;

  always_comb begin
    unique case (src_q)
      SRC_ID:  rsp_rdata = DATA_W'(CARD_ID);
      SRC_RAM: rsp_rdata = ram_rdata;
      default: rsp_rdata = '0;
    endcase
  end

endmodule

// File: rtl/bankwin_chk.sv
module bankwin_chk
  import bankwin_pkg::*;
#(
  parameter int ADDR_W           = 16,
  parameter int DATA_W           = 16,
  parameter int WIN_AW           = 14,
  parameter int WIN_SEL          = 1,
  parameter int SLOT_W           = 6,
  parameter int SLOT_LSB         = 8,
  parameter int RAM_SLOT         = 10,
  parameter logic [15:0] CARD_ID = 16'h0402
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_we,
  input logic [1:0]        sel_sub,
  input logic [DATA_W-1:0] sel_data,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [SLOT_W-1:0] slot_q,
  input map_mode_e         mode_q
);

  localparam int TAG_W = ADDR_W - WIN_AW;

  logic in_win;
  logic rd_now;
  assign in_win = (req_addr[ADDR_W-1:WIN_AW] == TAG_W'(WIN_SEL));
  assign rd_now = req_valid && !req_we;

  // R1: state right after reset
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (slot_q == '0) && (mode_q == MAP_HI_B));

  // R2: select write loads mode and slot
  a_r2_select_load: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> (mode_q == map_mode_e'($past(sel_sub))) &&
               (slot_q == $past(sel_data[SLOT_LSB +: SLOT_W])));

  a_r2_select_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(slot_q) && $stable(mode_q));

  // R3: foreign slot reads zero
  a_r3_foreign_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && (slot_q != SLOT_W'(RAM_SLOT))) |=> (rsp_rdata == '0));

  // R4: identification word in mode 0
  a_r4_card_id: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && in_win && (slot_q == SLOT_W'(RAM_SLOT)) && (mode_q == MAP_ID))
      |=> (rsp_rdata == DATA_W'(CARD_ID)));

  // R9: response exactly one cycle after a read
  a_r9_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now |=> rsp_valid);

  a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_now |=> !rsp_valid);

  // R10: outside the window reads zero
  a_r10_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && !in_win) |=> (rsp_rdata == '0));

  // R11: always ready
  a_r11_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

endmodule

bind bankwin_top bankwin_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .WIN_AW  (WIN_AW),
  .WIN_SEL (WIN_SEL),
  .SLOT_W  (SLOT_W),
  .SLOT_LSB(SLOT_LSB),
  .RAM_SLOT(RAM_SLOT),
  .CARD_ID (CARD_ID)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_we   (sel_we),
  .sel_sub  (sel_sub),
  .sel_data (sel_data),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_we   (req_we),
  .req_addr (req_addr),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .slot_q   (slot_q),
  .mode_q   (mode_q)
);

// File: tb/tb_bankwin_top.sv
`timescale 1ns/1ps
module tb_bankwin_top;

  localparam int HALF_AW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0;
  logic [1:0]  sel_sub = '0;
  logic [15:0] sel_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] req_wmask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;

  always #2 clk = ~clk;

  bankwin_top dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_we   (sel_we),
    .sel_sub  (sel_sub),
    .sel_data (sel_data),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_we   (req_we),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_wmask(req_wmask),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side model state, built from the requirements
  logic [5:0]  b_slot = 6'd0;
  logic [1:0]  b_mode = 2'd3;
  logic [15:0] mdl [0:(2<<HALF_AW)-1];

  logic [15:0] q_data [$];
  string       q_tag  [$];
  int          q_cyc  [$];

  function automatic bit in_win(input logic [15:0] a);
    return a[15:14] == 2'b01;
  endfunction

  function automatic int ridx(input logic [15:0] a);
    return int'({b_mode[1], a[HALF_AW-1:0]});
  endfunction

  function automatic logic [15:0] exp_read(input logic [15:0] a);
    if (!in_win(a) || b_slot != 6'd10) return 16'h0000;
    if (b_mode == 2'd0) return 16'h0402;
    return mdl[ridx(a)];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sel_write(input logic [1:0] sub, input logic [15:0] data);
    @(negedge clk);
    req_valid = 1'b0;
    sel_we    = 1'b1;
    sel_sub   = sub;
    sel_data  = data;
    b_mode    = sub;
    b_slot    = data[13:8];
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [15:0] m);
    @(negedge clk);
    sel_we    = 1'b0;
    req_valid = 1'b1;
    req_we    = 1'b1;
    req_addr  = a;
    req_wdata = d;
    req_wmask = m;
    if (in_win(a) && b_slot == 6'd10 && b_mode != 2'd0)
      mdl[ridx(a)] = (mdl[ridx(a)] & ~m) | (d & m);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    @(negedge clk);
    sel_we    = 1'b0;
    req_valid = 1'b1;
    req_we    = 1'b0;
    req_addr  = a;
    q_data.push_back(exp_read(a));
    q_tag.push_back(tag);
    q_cyc.push_back(cyc + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sel_we    = 1'b0;
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pops expected responses in order
  always @(negedge clk) begin
    if (rst_n) begin
      check("R11 req_ready", 32'(req_ready), 32'd1);
      if (rsp_valid) begin
        if (q_data.size() == 0) begin
          check("R9 unexpected response", 32'd1, 32'd0);
        end else begin
          logic [15:0] e;
          string t;
          int c;
          e = q_data.pop_front();
          t = q_tag.pop_front();
          c = q_cyc.pop_front();
          check({t, " latency"}, 32'(cyc), 32'(c));
          check(t, 32'(rsp_rdata), 32'(e));
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state gives zeros in the window
    rd(16'h4000, "R1 reset read low");
    rd(16'h7FFF, "R1 reset read high");
    wr(16'h4005, 16'hFFFF, 16'hFFFF);          // R3 slot 0, no effect

    // R2: upper data bits ignored, bits 13:8 = 0x0A
    sel_write(2'd1, 16'hCA55);
    wr(16'h4000, 16'h1111, 16'hFFFF);
    wr(16'h4001, 16'h2222, 16'hFFFF);
    wr(16'h43FF, 16'h3333, 16'hFFFF);
    wr(16'h4005, 16'h4444, 16'hFFFF);

    // R7: write upper via mode 2, read via mode 3 and back
    sel_write(2'd2, 16'h0A00);
    wr(16'h4000, 16'hAAAA, 16'hFFFF);
    wr(16'h4001, 16'hBBBB, 16'hFFFF);
    sel_write(2'd3, 16'h0A00);
    rd(16'h4000, "R7 mode3 sees mode2 data");
    wr(16'h4001, 16'hCCCC, 16'hFFFF);
    sel_write(2'd2, 16'h0A00);
    rd(16'h4001, "R7 mode2 sees mode3 data");

    // R6: lower half independent of upper
    sel_write(2'd1, 16'h0A00);
    rd(16'h4000, "R6 lower word 0");
    rd(16'h43FF, "R6 lower last word");
    rd(16'h4005, "R2 R3 slot-0 write did not land");

    // R8: masked write
    wr(16'h4001, 16'h0F0F, 16'h00FF);
    rd(16'h4001, "R8 low byte masked");
    wr(16'h4001, 16'hF0F0, 16'hF000);
    rd(16'h4001, "R8 top nibble masked");

    // R4, R5: identification mode
    sel_write(2'd0, 16'h0A00);
    rd(16'h4000, "R4 id at base");
    rd(16'h7FFF, "R4 id at top");
    wr(16'h4000, 16'h5555, 16'hFFFF);
    sel_write(2'd1, 16'h0A00);
    rd(16'h4000, "R5 id-mode write blocked");

    // R3: other slots
    sel_write(2'd1, 16'h0B00);
    rd(16'h4000, "R3 slot 11 reads zero");
    wr(16'h4000, 16'h9999, 16'hFFFF);
    sel_write(2'd1, 16'h2A00);
    rd(16'h4001, "R3 slot 0x2A reads zero");
    sel_write(2'd1, 16'h4A00);               // bit 14 ignored -> slot 10
    rd(16'h4000, "R2 R3 foreign write blocked");

    // R10: window bounds and wrap
    rd(16'h3FFF, "R10 below window");
    rd(16'h8000, "R10 above window");
    wr(16'h8000, 16'h7777, 16'hFFFF);
    wr(16'h0000, 16'h6666, 16'hFFFF);
    rd(16'h4000, "R10 outside writes blocked");
    rd(16'h4400, "R10 offset wraps");
    sel_write(2'd3, 16'h0A00);
    rd(16'h4401, "R10 wrap in upper half");

    // R9: back-to-back reads mixed with writes
    for (int i = 0; i < 8; i++) begin
      wr(16'h4100 + 16'(i), 16'h0100 * 16'(i) + 16'h00A5, 16'hFFFF);
    end
    for (int i = 0; i < 8; i++) begin
      rd(16'h4100 + 16'(i), "R9 back-to-back read");
    end
    idle(4);
    check("R9 all responses returned", 32'(q_data.size()), 32'd0);
    finish_run();
  end

endmodule